// File: doc/BRIEF.md
# Multiplexed Host Port Slave

This block gives an external host processor read and write access to on-chip word memory through a 16-bit parallel slave port. Two control lines choose what each host access addresses: an internal control register, an address register, or memory. Memory can be reached at a fixed address or with automatic post-increment, so a host can stream a block of words after writing one start address.

The host qualifies an access with an active-low chip select and an active-low data strobe. The access is the time both are low. These strobes are asynchronous to the core clock. They pass through a synchroniser before their edges are detected. The host holds the select lines, direction, byte enables and write data stable from before the strobes fall until they rise. An optional active-low address strobe lets the host present the select lines and direction early. A falling edge of that strobe captures them for the next access.

On the memory side there is one outstanding transaction at a time. The request is a valid/ready handshake. Once the request is valid, it holds address, data, write flag and byte enables unchanged until ready is seen. A write ends on that handshake. A read ends when the response valid pulse returns the data, which can happen any number of cycles later. The host-side ready output is low while a memory transaction is outstanding. The host must wait for it to be high before it ends the access and reads the data bus.

Top module: `hpi_slave`

## Requirements
- R1: After reset, host ready is 1 and the read data bus is 0. The control register and the address register both read 0.
- R2: Select code 00 addresses the control register. A host write stores the data, and a host read returns the stored value. There is no memory transaction.
- R3: Select code 10 addresses the address register. A write stores the base address and also loads the working memory address. A read returns the base address.
- R4: Select code 11 is a memory access at the working address, which stays unchanged. Repeated accesses hit the same word. Each access makes exactly one memory request.
- R5: Select code 01 is a memory access at the working address. After each such access completes, the working address is advanced by one word.
- R6: While auto-increment accesses advance the working address, a read of the address register still returns the base address last written.
- R7: Active-low byte enables qualify writes. Bit 0 covers data[7:0] and bit 1 covers data[15:8]. This holds for register writes and for memory writes, where mem_be is active high. Memory reads always request both bytes.
- R8: Host ready goes low in the cycle after an access to memory is recognised. It stays low while the request waits for ready or a read waits for its response, then returns high. Register accesses leave it high. A request held back by mem_req_ready=0 keeps its address, data and write flag stable.
- R9: An access exists only while chip select and data strobe are both low. A data strobe pulse with chip select high has no effect.
- R10: Suppose the address strobe has fallen since the last access. The next access then uses the select code and direction sampled at that fall, not the levels present when the data strobe falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hcs_n | input | 1 | Host chip select, active low |
| hds_n | input | 1 | Host data strobe, active low |
| has_n | input | 1 | Host address strobe, active low, captures select and direction |
| hrw | input | 1 | Direction: 1 read, 0 write |
| hctl | input | 2 | Select code (00 control, 10 address, 11 data, 01 data with increment) |
| hbe_n | input | 2 | Byte enables, active low |
| hd_in | input | 16 | Host write data |
| hd_out | output | 16 | Host read data |
| hd_oe | output | 1 | High while a read access drives the host bus |
| hrdy | output | 1 | Host ready; low while a memory transaction is outstanding |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word address of the request |
| mem_wdata | output | 16 | Write data |
| mem_be | output | 2 | Byte enables, active high |
| mem_rsp_valid | input | 1 | Read response valid (one pulse) |
| mem_rdata | input | 16 | Read response data |

## Verification
The hardest case to reach is an address register read that comes after a run of auto-increment accesses. The working address has then drifted from the base, and only a later fixed-address access shows how far it went. The bench writes a base, streams several incrementing writes, and reads the address register. It then rewrites the base, reads the same words back with increment, and makes a final fixed access that must land one word past the run. The memory model inserts random request back-pressure and random response delay, so the ready handshake is seen with several distinct wait lengths. Address-strobe capture is reached by changing the select lines between the address-strobe pulse and the data strobe.

// File: rtl/hpi_pkg.sv
`timescale 1ns/1ps
package hpi_pkg;
  localparam int HOST_W  = 16;
  localparam int HOST_NB = HOST_W / 8;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'b00,
    SEL_AUTO = 2'b01,
    SEL_ADDR = 2'b10,
    SEL_DATA = 2'b11
  } sel_e;

  typedef enum logic [1:0] {
    MP_IDLE = 2'b00,
    MP_REQ  = 2'b01,
    MP_RSP  = 2'b10
  } mp_state_e;

  function automatic logic [HOST_W-1:0] be_merge(
    input logic [HOST_W-1:0]  old_v,
    input logic [HOST_W-1:0]  new_v,
    input logic [HOST_NB-1:0] be_n
  );
    logic [HOST_W-1:0] r;
    r = old_v;
    for (int b = 0; b < HOST_NB; b++)
      if (!be_n[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
    return r;
  endfunction
endpackage

// File: rtl/hpi_sync.sv
`timescale 1ns/1ps
module hpi_sync #(
  parameter int            STAGES  = 2,
  parameter int            W       = 1,
  parameter logic [W-1:0]  RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hpi_regs.sv
`timescale 1ns/1ps
module hpi_regs
  import hpi_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_ctrl,
  input  logic               wr_addr,
  input  logic               inc,
  input  logic [HOST_W-1:0]  wdata,
  input  logic [HOST_NB-1:0] be_n,
  output logic [HOST_W-1:0]  ctrl_q,
  output logic [AW-1:0]      base_q,
  output logic [AW-1:0]      work_q
);
  logic [HOST_W-1:0] base_merged;
  assign base_merged = be_merge(HOST_W'(base_q), wdata, be_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      base_q <= '0;
      work_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= be_merge(ctrl_q, wdata, be_n);
      if (wr_addr) begin
        base_q <= AW'(base_merged);
        work_q <= AW'(base_merged);
      end else if (inc) begin
        work_q <= work_q + AW'(1);
      end
    end
  end
endmodule

// File: rtl/hpi_memport.sv
`timescale 1ns/1ps
module hpi_memport
  import hpi_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               we,
  input  logic [AW-1:0]      addr,
  input  logic [HOST_W-1:0]  wdata,
  input  logic [HOST_NB-1:0] be,
  output logic               idle,
  output logic               wr_done,
  output logic               rd_done,
  output logic [HOST_W-1:0]  rdata,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_we,
  output logic [AW-1:0]      mem_addr,
  output logic [HOST_W-1:0]  mem_wdata,
  output logic [HOST_NB-1:0] mem_be,
  input  logic               mem_rsp_valid,
  input  logic [HOST_W-1:0]  mem_rdata
);
  mp_state_e st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= MP_IDLE;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_be    <= '0;
    end else begin
      unique case (st)
        MP_IDLE: if (start) begin
          st        <= MP_REQ;
          mem_we    <= we;
          mem_addr  <= addr;
          mem_wdata <= we ? wdata : '0;
          mem_be    <= we ? be : '1;
        end
        MP_REQ: if (mem_req_ready) st <= mem_we ? MP_IDLE : MP_RSP;
        MP_RSP: if (mem_rsp_valid) st <= MP_IDLE;
        default: st <= MP_IDLE;
      endcase
    end
  end

  assign idle          = (st == MP_IDLE);
  assign mem_req_valid = (st == MP_REQ);
  assign wr_done       = (st == MP_REQ) && mem_req_ready && mem_we;
  assign rd_done       = (st == MP_RSP) && mem_rsp_valid;
  assign rdata         = mem_rdata;
endmodule

// File: rtl/hpi_slave.sv
`timescale 1ns/1ps
module hpi_slave
  import hpi_pkg::*;
#(
  parameter int AW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hcs_n,
  input  logic               hds_n,
  input  logic               has_n,
  input  logic               hrw,
  input  logic [1:0]         hctl,
  input  logic [HOST_NB-1:0] hbe_n,
  input  logic [HOST_W-1:0]  hd_in,
  output logic [HOST_W-1:0]  hd_out,
  output logic               hd_oe,
  output logic               hrdy,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_we,
  output logic [AW-1:0]      mem_addr,
  output logic [HOST_W-1:0]  mem_wdata,
  output logic [HOST_NB-1:0] mem_be,
  input  logic               mem_rsp_valid,
  input  logic [HOST_W-1:0]  mem_rdata
);
  logic [2:0] strb_s;
  logic cs_s, ds_s, as_s;

  hpi_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b111)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({hcs_n, hds_n, has_n}), .q(strb_s)
  );
  assign {cs_s, ds_s, as_s} = strb_s;

  logic acc_act, acc_act_q, acc_start, as_q, as_fall;
  logic as_pend, as_rw;
  sel_e as_sel, eff_sel;
  logic eff_rw, op_rw_q, op_auto_q;

  assign acc_act   = !cs_s && !ds_s;
  assign as_fall   = !as_s && as_q;

  logic mp_idle, wr_done, rd_done;
  logic [HOST_W-1:0] mp_rdata;
  logic [HOST_W-1:0] ctrl_q;
  logic [AW-1:0]     base_q, work_q;

  assign acc_start = acc_act && !acc_act_q && mp_idle;
  assign eff_sel   = as_pend ? as_sel : sel_e'(hctl);
  assign eff_rw    = as_pend ? as_rw  : hrw;

  logic is_mem, wr_ctrl, wr_addr;
  assign is_mem  = eff_sel[0];
  assign wr_ctrl = acc_start && !eff_rw && (eff_sel == SEL_CTRL);
  assign wr_addr = acc_start && !eff_rw && (eff_sel == SEL_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_act_q <= 1'b0;
      as_q      <= 1'b1;
      as_pend   <= 1'b0;
      as_sel    <= SEL_CTRL;
      as_rw     <= 1'b0;
      op_rw_q   <= 1'b0;
      op_auto_q <= 1'b0;
      hd_out    <= '0;
    end else begin
      acc_act_q <= acc_act;
      as_q      <= as_s;
      if (acc_start) begin
        as_pend   <= 1'b0;
        op_rw_q   <= eff_rw;
        op_auto_q <= (eff_sel == SEL_AUTO);
        if (eff_rw && eff_sel == SEL_CTRL) hd_out <= ctrl_q;
        if (eff_rw && eff_sel == SEL_ADDR) hd_out <= HOST_W'(base_q);
      end else if (as_fall) begin
        as_pend <= 1'b1;
        as_sel  <= sel_e'(hctl);
        as_rw   <= hrw;
      end
      if (rd_done) hd_out <= mp_rdata;
    end
  end

  hpi_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_ctrl(wr_ctrl), .wr_addr(wr_addr),
    .inc((wr_done || rd_done) && op_auto_q),
    .wdata(hd_in), .be_n(hbe_n),
    .ctrl_q(ctrl_q), .base_q(base_q), .work_q(work_q)
  );

  hpi_memport #(.AW(AW)) u_mp (
    .clk(clk), .rst_n(rst_n),
    .start(acc_start && is_mem), .we(!eff_rw),
    .addr(work_q), .wdata(hd_in), .be(~hbe_n),
    .idle(mp_idle), .wr_done(wr_done), .rd_done(rd_done), .rdata(mp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata)
  );

  assign hrdy  = mp_idle;
  assign hd_oe = acc_act_q && op_rw_q;
endmodule

// File: rtl/hpi_slave_chk.sv
`timescale 1ns/1ps
module hpi_slave_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hrdy,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [15:0]   mem_wdata,
  input logic [1:0]    mem_be,
  input logic          mem_rsp_valid,
  input logic          acc_start
);
  // R8
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !hrdy);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr)
      && $stable(mem_wdata) && $stable(mem_we));

  // R8
  ready_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hrdy) |-> $past(mem_rsp_valid || (mem_req_valid && mem_req_ready && mem_we)));

  // R7
  read_full_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_we |-> mem_be == 2'b11);

  // R4
  req_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> $past(acc_start));
endmodule

bind hpi_slave hpi_slave_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hrdy(hrdy),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_be(mem_be), .mem_rsp_valid(mem_rsp_valid), .acc_start(acc_start)
);

// File: tb/tb_hpi_slave.sv
`timescale 1ns/1ps
module tb_hpi_slave;
  localparam int AW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hcs_n = 1'b1, hds_n = 1'b1, has_n = 1'b1, hrw = 1'b1;
  logic [1:0] hctl = 2'b00, hbe_n = 2'b00;
  logic [15:0] hd_in = '0, hd_out;
  logic hd_oe, hrdy;
  logic mem_req_valid, mem_req_ready, mem_we, mem_rsp_valid;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [1:0] mem_be;

  always #4 clk = ~clk;

  hpi_slave #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .hcs_n(hcs_n), .hds_n(hds_n), .has_n(has_n),
    .hrw(hrw), .hctl(hctl), .hbe_n(hbe_n), .hd_in(hd_in), .hd_out(hd_out),
    .hd_oe(hd_oe), .hrdy(hrdy), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rsp_valid(mem_rsp_valid),
    .mem_rdata(mem_rdata)
  );

  // memory model with random back-pressure and response delay
  logic [15:0] mem [256];
  logic [15:0] exp_mem [256];
  logic [2:0]  rsp_cnt = '0;
  logic [7:0]  rsp_idx = '0;
  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]     = 16'hA000 + 16'(i * 7);
      exp_mem[i] = 16'hA000 + 16'(i * 7);
    end
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rdata     = '0;
  end
  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    mem_req_ready <= ($urandom % 3) != 0;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_we) begin
        for (int b = 0; b < 2; b++)
          if (mem_be[b]) mem[mem_addr[7:0]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
      end else begin
        rsp_cnt <= 3'(1 + $urandom % 3);
        rsp_idx <= mem_addr[7:0];
      end
    end
    if (rsp_cnt != 0) begin
      rsp_cnt <= rsp_cnt - 3'd1;
      if (rsp_cnt == 3'd1) begin
        mem_rsp_valid <= 1'b1;
        mem_rdata     <= mem[rsp_idx];
      end
    end
  end

  int total = 0, bad = 0;
  logic [15:0] e_ctrl = '0, e_base = '0, e_work = '0;

  function automatic logic [15:0] merge(input logic [15:0] o, input logic [15:0] n,
                                        input logic [1:0] be_n);
    logic [15:0] r = o;
    if (!be_n[0]) r[7:0]  = n[7:0];
    if (!be_n[1]) r[15:8] = n[15:8];
    return r;
  endfunction

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic acc(input logic rw, input logic [1:0] ctl, input logic [15:0] d,
                     input logic [1:0] be_n, output logic [15:0] rd, output logic rdy_mid);
    @(negedge clk);
    hrw = rw; hctl = ctl; hd_in = d; hbe_n = be_n; hcs_n = 1'b0;
    @(negedge clk);
    hds_n = 1'b0;
    repeat (3) @(negedge clk);
    rdy_mid = hrdy;
    repeat (2) @(negedge clk);
    while (!hrdy) @(negedge clk);
    rd = hd_out;
    hds_n = 1'b1; hcs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // register and memory operations with model update
  task automatic op_reg(input string req, input logic rw, input logic [1:0] ctl,
                        input logic [15:0] d, input logic [1:0] be_n);
    logic [15:0] rd; logic mid;
    acc(rw, ctl, d, be_n, rd, mid);
    chk({req, " reg access keeps ready"}, {15'd0, mid}, 16'd1);
    if (!rw) begin
      if (ctl == 2'b00) e_ctrl = merge(e_ctrl, d, be_n);
      else begin e_base = merge(e_base, d, be_n); e_work = e_base; end
    end else begin
      chk(req, rd, (ctl == 2'b00) ? e_ctrl : e_base);
    end
  endtask

  task automatic op_mem(input string req, input logic rw, input logic auto,
                        input logic [15:0] d, input logic [1:0] be_n);
    logic [15:0] rd; logic mid;
    acc(rw, auto ? 2'b01 : 2'b11, d, be_n, rd, mid);
    chk("R8 ready low during memory access", {15'd0, mid}, 16'd0);
    if (rw) chk(req, rd, exp_mem[e_work[7:0]]);
    else    exp_mem[e_work[7:0]] = merge(exp_mem[e_work[7:0]], d, be_n);
    if (auto) e_work = e_work + 16'd1;
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 hrdy after reset", {15'd0, hrdy}, 16'd1);
    chk("R1 hd_out after reset", hd_out, 16'h0000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    op_reg("R1 control reads 0", 1'b1, 2'b00, 16'h0, 2'b00);
    op_reg("R1 address reads 0", 1'b1, 2'b10, 16'h0, 2'b00);

    // R2 control register
    op_reg("R2 write ctrl", 1'b0, 2'b00, 16'h1234, 2'b00);
    op_reg("R2 read ctrl", 1'b1, 2'b00, 16'h0, 2'b00);
    // R7 byte enable on register write (upper byte disabled)
    op_reg("R7 ctrl low byte only", 1'b0, 2'b00, 16'hABCD, 2'b10);
    op_reg("R7 ctrl merged", 1'b1, 2'b00, 16'h0, 2'b00);

    // R3 address register
    op_reg("R3 write addr", 1'b0, 2'b10, 16'h0010, 2'b00);
    op_reg("R3 read addr", 1'b1, 2'b10, 16'h0, 2'b00);

    // R4 fixed data access
    op_mem("R4 fixed read", 1'b1, 1'b0, 16'h0, 2'b00);
    op_mem("R4 fixed read again", 1'b1, 1'b0, 16'h0, 2'b00);
    op_mem("R4 fixed write", 1'b0, 1'b0, 16'h5555, 2'b00);
    op_mem("R4 fixed readback", 1'b1, 1'b0, 16'h0, 2'b00);

    // R5 / R6 auto-increment run
    op_reg("R5 base", 1'b0, 2'b10, 16'h0020, 2'b00);
    for (int i = 0; i < 4; i++)
      op_mem("R5 inc write", 1'b0, 1'b1, 16'h7700 + 16'(i), 2'b00);
    op_reg("R6 addr read after inc", 1'b1, 2'b10, 16'h0, 2'b00);
    op_reg("R5 rebase", 1'b0, 2'b10, 16'h0020, 2'b00);
    for (int i = 0; i < 4; i++)
      op_mem("R5 inc read", 1'b1, 1'b1, 16'h0, 2'b00);
    op_mem("R5 fixed read past run", 1'b1, 1'b0, 16'h0, 2'b00);
    op_reg("R6 addr read again", 1'b1, 2'b10, 16'h0, 2'b00);

    // R7 memory byte enables (upper byte only)
    op_reg("R7 base", 1'b0, 2'b10, 16'h0030, 2'b00);
    op_mem("R7 upper byte write", 1'b0, 1'b0, 16'hFFFF, 2'b01);
    op_mem("R7 upper byte readback", 1'b1, 1'b0, 16'h0, 2'b00);

    // R9 data strobe with chip select high: no effect
    @(negedge clk);
    hcs_n = 1'b1; hrw = 1'b0; hctl = 2'b00; hd_in = 16'hDEAD; hbe_n = 2'b00;
    hds_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 no ready drop without cs", {15'd0, hrdy}, 16'd1);
    repeat (5) @(negedge clk);
    hds_n = 1'b1;
    repeat (4) @(negedge clk);
    op_reg("R9 ctrl unchanged", 1'b1, 2'b00, 16'h0, 2'b00);

    // R10 address-strobe capture: latch write-to-address, then change lines
    @(negedge clk);
    hctl = 2'b10; hrw = 1'b0; has_n = 1'b0;
    repeat (4) @(negedge clk);
    has_n = 1'b1;
    repeat (4) @(negedge clk);
    begin
      logic [15:0] rd; logic mid;
      acc(1'b1, 2'b00, 16'h0040, 2'b00, rd, mid);
      e_base = 16'h0040; e_work = 16'h0040;
    end
    op_reg("R10 addr written via strobe", 1'b1, 2'b10, 16'h0, 2'b00);
    op_reg("R10 ctrl untouched", 1'b1, 2'b00, 16'h0, 2'b00);

    // random mix
    for (int n = 0; n < 80; n++) begin
      int k = $urandom % 6;
      logic [15:0] d = 16'($urandom);
      logic [1:0] be = 2'($urandom);
      case (k)
        0: op_reg("R3 rnd addr write", 1'b0, 2'b10, {8'h00, d[7:0]}, 2'b00);
        1: op_reg("R6 rnd addr read", 1'b1, 2'b10, 16'h0, 2'b00);
        2: op_reg(be[0] ? "R2 rnd ctrl write" : "R2 rnd ctrl read", ~be[0], 2'b00, d, 2'b00);
        3: op_mem("R4 rnd fixed", d[0], 1'b0, d, be);
        default: op_mem("R5 rnd inc", d[0], 1'b1, d, be);
      endcase
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule